// File: doc/BRIEF.md
# Cascadable Dual Timer with Differential Output

The block holds two 8-bit up-counter stages. Each stage owns a compare register. The stages either run as two separate 8-bit timers or are chained into one 16-bit timer. A 4-bit mode code, loaded through a write strobe, selects the arrangement. It also selects whether an end-of-measurement strobe captures the lower counter. The counters advance only on cycles where the prescaled clock enable is high. Clock source and prescaler logic sit outside the block.

Each compare event toggles an internal output level. Two pins carry that level. The first pin follows it directly. The second pin can be inverted, so the pair drives a load differentially. A compare event also raises a one-cycle interrupt pulse unless the mask input is set. A sticky flag records lower-stage overflow.

A synchronous reset control stops the counting, clears both counters and both capture registers, and drops all interrupt status. Compare writes take effect at once. Nothing hides a stray match that can occur between the writes of the lower and upper compare values.

Top module: `dtmr_top`

## Requirements
- R1: After block reset the mode register holds 1111b. Mode codes: 0000 = 8-bit timer, 0001 = 16-bit timer, 0010 = 8-bit measure, 0011 = 16-bit measure. Every other code is idle, and in idle both counters hold their value while the clock enable pulses.
- R2: In 8-bit modes each stage adds one on every enabled cycle. When a stage equals its compare value on such a cycle, it returns to 0 instead, so the lower stage repeats every compare+1 enables. Compare registers reset to all ones.
- R3: A compare event (lower-stage match in 8-bit modes, full 16-bit match in 16-bit modes) toggles the output level. The same event gives `cmp_irq` high for exactly the one cycle after that edge when `cmp_mask` is 0, and no pulse when `cmp_mask` is 1.
- R4: An enabled cycle with the lower counter at all ones sets `ovf_irq`. The flag stays set until the reset control clears it.
- R5: In 16-bit modes the upper stage adds one on every enabled cycle where the lower stage either matches its compare value or sits at all ones, whatever `cmp_mask` holds. The lower stage returns to 0 on its own match.
- R6: In 16-bit modes a compare event needs both stages to match on the same enabled cycle. That cycle returns both counters to 0. A lower-only match raises no event.
- R7: In measure modes an `eom` pulse loads `cap_lo` with the lower count. In timer modes `eom` has no effect. `cap_hi` is a shadow that copies the upper counter one cycle later.
- R8: While `tmr_rst` is high, both counters and both capture registers read 0, `cmp_irq` and `ovf_irq` read 0, and the clock enable has no effect.
- R9: `pin_a` equals the output level. `pin_b` equals the output level XOR the `out_inv` value seen at the previous edge.
- R10: A compare write counts from the next enabled cycle. Writing values equal to the current counts gives a compare event on the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| cen | input | 1 | Prescaled count enable |
| mode_we | input | 1 | Mode register write strobe |
| mode_wd | input | 4 | Mode code to write |
| tmr_rst | input | 1 | Reset-and-halt control |
| out_inv | input | 1 | Invert the second output pin |
| cmp_mask | input | 1 | Mask the compare interrupt |
| eom | input | 1 | End-of-measurement strobe |
| cmp_lo_we | input | 1 | Lower compare write strobe |
| cmp_hi_we | input | 1 | Upper compare write strobe |
| cmp_wd | input | 8 | Compare write data |
| cnt_lo | output | 8 | Lower counter |
| cnt_hi | output | 8 | Upper counter |
| cap_lo | output | 8 | Lower capture register |
| cap_hi | output | 8 | Upper shadow register |
| cmp_irq | output | 1 | Compare interrupt pulse |
| ovf_irq | output | 1 | Sticky overflow flag |
| pin_a | output | 1 | Output pin following the output level |
| pin_b | output | 1 | Output pin, optionally inverted |

## Verification
The counters, the output level, both pins, the overflow flag and the compare pulse all change at the clock edge that samples `cen` high. `cap_lo` changes at the edge that samples `eom`. The shadow `cap_hi` and the `out_inv` effect on `pin_b` each need one more edge. The bench drives every input on the falling edge and reads results at the next falling edge after the edge that updates them. The compare pulse is therefore read on the cycle it is high and again one cycle later, when it must be low.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_T8   = 4'b0000,
    M_T16  = 4'b0001,
    M_MS8  = 4'b0010,
    M_MS16 = 4'b0011,
    M_IDLE = 4'b1111
  } mode_e;

  function automatic logic mode_runs(input logic [MODE_W-1:0] m);
    return (m[MODE_W-1:2] == '0);
  endfunction

  function automatic logic mode_chain(input logic [MODE_W-1:0] m);
    return mode_runs(m) && m[0];
  endfunction

  function automatic logic mode_meas(input logic [MODE_W-1:0] m);
    return mode_runs(m) && m[1];
  endfunction
endpackage

// File: rtl/dtmr_stage.sv
module dtmr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         halt,
  input  logic         step,
  input  logic         zero,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wd,
  output logic [W-1:0] cnt,
  output logic         match,
  output logic         at_max
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmp_q <= ALL1;
    end else begin
      if (cmp_we) cmp_q <= cmp_wd;
      if (halt)      cnt <= '0;
      else if (step) cnt <= zero ? '0 : cnt + 1'b1;
    end
  end

  assign match  = (cnt == cmp_q);
  assign at_max = (cnt == ALL1);

  // R2: a plain step adds exactly one
  a_r2_step_inc: assert property (@(posedge clk) disable iff (rst)
    (step && !zero && !halt) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R8: halt forces the count to zero
  a_r8_halt_zero: assert property (@(posedge clk) disable iff (rst)
    halt |=> (cnt == '0));
endmodule

// File: rtl/dtmr_outpair.sv
module dtmr_outpair (
  input  logic clk,
  input  logic rst,
  input  logic toggle,
  input  logic inv,
  output logic pin_a,
  output logic pin_b
);
  logic lvl_q, lvl_n;

  assign lvl_n = lvl_q ^ toggle;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pin_b <= 1'b0;
    end else begin
      lvl_q <= lvl_n;
      pin_b <= lvl_n ^ inv;
    end
  end

  assign pin_a = lvl_q;

  // R9: the pins differ exactly when invert was requested
  a_r9_pin_pair: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_a ^ pin_b) == $past(inv)));

  // R3: the level moves only on a compare event
  a_r3_toggle_only: assert property (@(posedge clk) disable iff (rst)
    !toggle |=> $stable(pin_a));
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
  import dtmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wd,
  input  logic              tmr_rst,
  input  logic              out_inv,
  input  logic              cmp_mask,
  input  logic              eom,
  input  logic              cmp_lo_we,
  input  logic              cmp_hi_we,
  input  logic [W-1:0]      cmp_wd,
  output logic [W-1:0]      cnt_lo,
  output logic [W-1:0]      cnt_hi,
  output logic [W-1:0]      cap_lo,
  output logic [W-1:0]      cap_hi,
  output logic              cmp_irq,
  output logic              ovf_irq,
  output logic              pin_a,
  output logic              pin_b
);
  logic [MODE_W-1:0] mode_q;
  logic run, chain, meas;
  logic lo_match, hi_match, lo_max, hi_max;
  logic lo_step, lo_zero, hi_step, hi_zero;
  logic full_match, cmp_ev, ovf_ev;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= M_IDLE;
    else if (mode_we) mode_q <= mode_wd;
  end

  assign chain = mode_chain(mode_q);
  assign meas  = mode_meas(mode_q);
  assign run   = cen && mode_runs(mode_q) && !tmr_rst;

  assign full_match = lo_match && hi_match;
  assign ovf_ev     = run && lo_max;

  // lower stage always steps on run and clears on its own match
  assign lo_step = run;
  assign lo_zero = lo_match;

  // upper stage: independent in 8-bit modes, driven by lower events when chained
  assign hi_step = chain ? (run && (lo_match || lo_max)) : run;
  assign hi_zero = chain ? full_match : hi_match;

  assign cmp_ev = run && (chain ? full_match : lo_match);

  dtmr_stage #(.W(W)) u_lo (
    .clk(clk), .rst(rst), .halt(tmr_rst), .step(lo_step), .zero(lo_zero),
    .cmp_we(cmp_lo_we), .cmp_wd(cmp_wd),
    .cnt(cnt_lo), .match(lo_match), .at_max(lo_max)
  );

  dtmr_stage #(.W(W)) u_hi (
    .clk(clk), .rst(rst), .halt(tmr_rst), .step(hi_step), .zero(hi_zero),
    .cmp_we(cmp_hi_we), .cmp_wd(cmp_wd),
    .cnt(cnt_hi), .match(hi_match), .at_max(hi_max)
  );

  always_ff @(posedge clk) begin
    if (rst || tmr_rst) begin
      cap_lo  <= '0;
      cap_hi  <= '0;
      cmp_irq <= 1'b0;
      ovf_irq <= 1'b0;
    end else begin
      if (meas && eom) cap_lo <= cnt_lo;
      cap_hi  <= cnt_hi;
      cmp_irq <= cmp_ev && !cmp_mask;
      if (ovf_ev) ovf_irq <= 1'b1;
    end
  end

  dtmr_outpair u_out (
    .clk(clk), .rst(rst), .toggle(cmp_ev), .inv(out_inv),
    .pin_a(pin_a), .pin_b(pin_b)
  );

  // R3: a masked request never pulses
  a_r3_mask: assert property (@(posedge clk) disable iff (rst)
    cmp_irq |-> !$past(cmp_mask));

  // R4: the overflow flag holds until the reset control
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_irq && !tmr_rst) |=> ovf_irq);

  // R6: a lower-only match in chained mode leaves the pins alone
  a_r6_need_both: assert property (@(posedge clk) disable iff (rst)
    (chain && run && lo_match && !hi_match) |=> (!cmp_irq && $stable(pin_a)));

  // R7: the shadow follows the upper counter
  a_r7_shadow: assert property (@(posedge clk) disable iff (rst)
    !tmr_rst |=> (cap_hi == $past(cnt_hi)));

  // R8: reset control clears status
  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    tmr_rst |=> (!cmp_irq && !ovf_irq && cap_lo == '0 && cap_hi == '0));

  // R1: idle codes freeze both counters
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!mode_runs(mode_q) && !tmr_rst) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: tb/tb_dtmr_top.sv
module tb_dtmr_top;
  logic clk = 1'b0;
  logic rst, cen, mode_we, tmr_rst, out_inv, cmp_mask, eom, cmp_lo_we, cmp_hi_we;
  logic [3:0] mode_wd;
  logic [7:0] cmp_wd;
  logic [7:0] cnt_lo, cnt_hi, cap_lo, cap_hi;
  logic cmp_irq, ovf_irq, pin_a, pin_b;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dtmr_top dut (
    .clk(clk), .rst(rst), .cen(cen), .mode_we(mode_we), .mode_wd(mode_wd),
    .tmr_rst(tmr_rst), .out_inv(out_inv), .cmp_mask(cmp_mask), .eom(eom),
    .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .cmp_wd(cmp_wd),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .pin_a(pin_a), .pin_b(pin_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count(input int n);
    cen = 1'b1;
    repeat (n) @(negedge clk);
    cen = 1'b0;
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_we = 1'b1; mode_wd = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [7:0] v);
    cmp_lo_we = 1'b1; cmp_wd = v;
    @(negedge clk);
    cmp_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [7:0] v);
    cmp_hi_we = 1'b1; cmp_wd = v;
    @(negedge clk);
    cmp_hi_we = 1'b0;
  endtask

  task automatic clr_tmr();
    tmr_rst = 1'b1;
    @(negedge clk);
    tmr_rst = 1'b0;
  endtask

  task automatic t_reset_idle();
    check("R1 cnt_lo after reset", cnt_lo, 0);
    check("R9 pin_a after reset", pin_a, 0);
    check("R9 pin_b after reset", pin_b, 0);
    check("R4 ovf after reset", ovf_irq, 0);
    count(3);
    check("R1 idle holds cnt_lo", cnt_lo, 0);
    check("R1 idle holds cnt_hi", cnt_hi, 0);
  endtask

  task automatic t_eight_bit();
    set_mode(4'b0000);
    wr_lo(8'd3);
    count(3);
    check("R2 cnt_lo after 3", cnt_lo, 3);
    check("R2 cnt_hi independent", cnt_hi, 3);
    check("R3 no irq before match", cmp_irq, 0);
    count(1);
    check("R2 wrap on match", cnt_lo, 0);
    check("R3 irq pulse", cmp_irq, 1);
    check("R3 pin toggled", pin_a, 1);
    @(negedge clk);
    check("R3 irq one cycle", cmp_irq, 0);
    cmp_mask = 1'b1;
    count(4);
    check("R3 masked irq", cmp_irq, 0);
    check("R3 masked still toggles", pin_a, 0);
    cmp_mask = 1'b0;
  endtask

  task automatic t_overflow();
    clr_tmr();
    wr_lo(8'hFF);
    count(255);
    check("R4 no ovf at FF", ovf_irq, 0);
    check("R4 cnt at FF", cnt_lo, 255);
    count(1);
    check("R4 ovf set", ovf_irq, 1);
    count(3);
    check("R4 ovf sticky", ovf_irq, 1);
    clr_tmr();
    check("R8 ovf cleared", ovf_irq, 0);
  endtask

  task automatic t_chain();
    logic p0;
    clr_tmr();
    set_mode(4'b0001);
    wr_lo(8'd2);
    wr_hi(8'd1);
    cmp_mask = 1'b1;
    p0 = pin_a;
    count(3);
    check("R5 hi steps on lo match with mask set", cnt_hi, 1);
    check("R5 lo cleared on own match", cnt_lo, 0);
    check("R6 no toggle on lo-only match", pin_a, p0);
    count(3);
    check("R6 both clear lo", cnt_lo, 0);
    check("R6 both clear hi", cnt_hi, 0);
    check("R6 toggle on full match", pin_a, !p0);
    cmp_mask = 1'b0;
    count(5);
    check("R6 no irq early", cmp_irq, 0);
    count(1);
    check("R6 irq on full match", cmp_irq, 1);
    clr_tmr();
    wr_lo(8'hFF);
    wr_hi(8'd3);
    count(256);
    check("R5 hi steps on overflow", cnt_hi, 1);
    check("R5 lo wrapped", cnt_lo, 0);
  endtask

  task automatic t_capture();
    clr_tmr();
    set_mode(4'b0010);
    wr_lo(8'hFF);
    wr_hi(8'hFF);
    count(5);
    eom = 1'b1;
    @(negedge clk);
    eom = 1'b0;
    check("R7 capture lo", cap_lo, 5);
    check("R7 shadow hi", cap_hi, 5);
    set_mode(4'b0000);
    count(2);
    eom = 1'b1;
    @(negedge clk);
    eom = 1'b0;
    check("R7 eom ignored in timer mode", cap_lo, 5);
    tmr_rst = 1'b1;
    count(3);
    check("R8 halted cnt_lo", cnt_lo, 0);
    check("R8 halted cnt_hi", cnt_hi, 0);
    check("R8 cap_lo cleared", cap_lo, 0);
    check("R8 cap_hi cleared", cap_hi, 0);
    tmr_rst = 1'b0;
  endtask

  task automatic t_invert();
    out_inv = 1'b1;
    @(negedge clk);
    check("R9 pins complementary", pin_a ^ pin_b, 1);
    out_inv = 1'b0;
    @(negedge clk);
    check("R9 pins equal", pin_a ^ pin_b, 0);
  endtask

  task automatic t_spurious();
    clr_tmr();
    set_mode(4'b0001);
    wr_lo(8'd2);
    wr_hi(8'd1);
    count(1);
    check("R10 lo at 1", cnt_lo, 1);
    wr_lo(8'd1);
    wr_hi(8'd0);
    count(1);
    check("R10 immediate irq", cmp_irq, 1);
    check("R10 cleared lo", cnt_lo, 0);
    check("R10 cleared hi", cnt_hi, 0);
  endtask

  initial begin
    rst = 1'b1; cen = 1'b0; mode_we = 1'b0; mode_wd = '0; tmr_rst = 1'b0;
    out_inv = 1'b0; cmp_mask = 1'b0; eom = 1'b0; cmp_lo_we = 1'b0;
    cmp_hi_we = 1'b0; cmp_wd = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_idle();
    t_eight_bit();
    t_overflow();
    t_chain();
    t_capture();
    t_invert();
    t_spurious();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule